// File: doc/BRIEF.md
# Read-to-Acquire Hardware Semaphore

This block is a one-bit lock that lets two bus agents, a host driver and an embedded firmware agent, take turns programming a shared steering selector. Each agent has its own register port. An agent takes the lock by reading the semaphore register. The read returns the word 1 only to the agent that has just become owner; every other read returns 0. The owner gives the lock back by writing the word 1. Any other write does nothing.

When the lock is free and several agents read it in the same cycle, a rotating priority pointer picks the winner. After any grant, priority passes to the next agent after the winner, so with two agents the grant alternates. Each agent that polls without success has its own timer. After a programmed number of cycles the timer raises a sticky timeout flag, which a requester's driver can report as a failed acquisition.

The agent count, data width and timeout length are parameters. Ports that exist once per agent are packed vectors indexed by agent number: agent a uses bit a, or the slice [a*DATA_W +: DATA_W]. The input reset is asynchronous, active low, and is released through a two-stage synchronizer.

Top module: `hsem_top`

## Requirements
- R1: After reset the lock is free (`owned` = 0), every timeout flag is 0 and every read data word is 0.
- R2: When the lock is free and only one agent reads, that agent's read data in the next cycle is the word 1. From that cycle `owned` = 1 and `owner` holds the reader's agent number.
- R3: While the lock is held, every read returns the word 0, including a repeated read by the owner, and the owner does not change.
- R4: When the lock is free and two or more agents read in the same cycle, the agent with priority gets 1 and the others get 0. Agent 0 has priority after reset. After any grant, priority passes to the agent numbered one above the winner, wrapping to 0.
- R5: A write of the word 1 by the current owner frees the lock; `owned` is 0 in the next cycle.
- R6: A write of the word 1 by an agent that is not the owner, and any write of a value other than 1 by any agent, leaves `owned` and `owner` unchanged.
- R7: A read in the same cycle as the owner's release sees the lock as still held and returns 0. The lock is free afterwards.
- R8: The first read that an agent is denied arms that agent's timer. If the agent gets no grant, its timeout flag rises exactly TMO_CYCLES cycles after that read and stays at 1 until reset. A grant before then disarms the timer without raising the flag.
- R9: In a cycle after one in which an agent did not read, that agent's read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rd_en | input | N_AGENTS | Per-agent read strobe of the semaphore register |
| wr_en | input | N_AGENTS | Per-agent write strobe of the semaphore register |
| wr_data | input | N_AGENTS*DATA_W | Per-agent write data; agent a uses slice [a*DATA_W +: DATA_W] |
| rd_data | output | N_AGENTS*DATA_W | Per-agent registered read data: 1 on a grant, otherwise 0 |
| timeout | output | N_AGENTS | Per-agent sticky polling-timeout flag |
| owned | output | 1 | 1 while some agent holds the lock |
| owner | output | $clog2(N_AGENTS) | Agent number of the owner; meaningful when owned = 1 |

## Verification
The bench targets four situations:

- **Contested read of a free lock.** A design with a fixed priority would hand every tie to agent 0. A design that forgets the tie would return 1 to both agents.
- **Repeated read by the owner.** A design that confuses "owned by me" with "free" would return 1 a second time.
- **Writes that must not release.** These are a non-owner writing 1 and the owner writing a value other than 1. A design that tested only bit 0, or ignored the writer's identity, would free the lock early.
- **Timeout edges.** The bench checks the exact cycle the flag rises, that the flag stays high, and that a grant in time disarms the timer. An off-by-one or a counter that is never cleared shows up as a flag that is early, late or spurious.

// File: rtl/hsem_pkg.sv
package hsem_pkg;

  // Width of an agent index; never below one bit.
  function automatic int agent_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Next agent index after idx, wrapping at n.
  function automatic int wrap_next(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Word value that releases the lock on a write.
  localparam int unsigned RELEASE_WORD = 1;

endpackage

// File: rtl/hsem_grant.sv
module hsem_grant #(
  parameter int N  = 2,
  parameter int AW = 1
) (
  input  logic [N-1:0]  rd_req,
  input  logic          busy,
  input  logic [AW-1:0] prio,
  output logic [N-1:0]  win,
  output logic [AW-1:0] win_id,
  output logic          any_win
);

  // Scan the readers starting at the priority pointer; the first one wins.
  always_comb begin : scan
    int idx;
    win     = '0;
    win_id  = prio;
    any_win = 1'b0;
    idx     = 0;
    if (!busy) begin
      for (int k = 0; k < N; k++) begin
        idx = int'(prio) + k;
        if (idx >= N) idx = idx - N;
        if (!any_win && rd_req[idx]) begin
          any_win  = 1'b1;
          win[idx] = 1'b1;
          win_id   = AW'(idx);
        end
      end
    end
  end

endmodule

// File: rtl/hsem_tmo.sv
module hsem_tmo #(
  parameter int TMO = 1250,
  localparam int CW = $clog2(TMO + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic deny,
  input  logic grant,
  output logic flag
);

  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          en;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    flag_d  = flag_q;
    if (grant) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (armed_q) begin
      if (!flag_q) begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q + CW'(1) == CW'(TMO)) flag_d = 1'b1;
      end
    end else if (deny) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end
  end

  assign en = grant | deny | armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      flag_q  <= 1'b0;
    end else if (en) begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      flag_q  <= flag_d;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/hsem_top.sv
module hsem_top
  import hsem_pkg::*;
#(
  parameter int N_AGENTS   = 2,
  parameter int DATA_W     = 32,
  parameter int TMO_CYCLES = 1250,
  localparam int AW = agent_w(N_AGENTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_AGENTS-1:0]        rd_en,
  input  logic [N_AGENTS-1:0]        wr_en,
  input  logic [N_AGENTS*DATA_W-1:0] wr_data,
  output logic [N_AGENTS*DATA_W-1:0] rd_data,
  output logic [N_AGENTS-1:0]        timeout,
  output logic                       owned,
  output logic [AW-1:0]              owner
);

  // Reset synchronizer: asserts at once, releases after two edges.
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // Lock state.
  logic          own_v_q, own_v_d;
  logic [AW-1:0] own_id_q, own_id_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          state_en;

  logic [N_AGENTS-1:0] win;
  logic [AW-1:0]       win_id;
  logic                any_win;
  logic [N_AGENTS-1:0] rel;
  logic                release_lock;

  hsem_grant #(.N(N_AGENTS), .AW(AW)) u_grant (
    .rd_req  (rd_en),
    .busy    (own_v_q),
    .prio    (ptr_q),
    .win     (win),
    .win_id  (win_id),
    .any_win (any_win)
  );

  // Per-agent release decode, read data register and timeout timer.
  for (genvar a = 0; a < N_AGENTS; a++) begin : g_agent
    logic [DATA_W-1:0] rdq;

    assign rel[a] = own_v_q && (own_id_q == AW'(a)) && wr_en[a] &&
                    (wr_data[a*DATA_W +: DATA_W] == DATA_W'(RELEASE_WORD));

    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i)                 rdq <= '0;
      else if (rd_en[a] || rdq[0]) rdq <= DATA_W'(win[a]);
    end
    assign rd_data[a*DATA_W +: DATA_W] = rdq;

    hsem_tmo #(.TMO(TMO_CYCLES)) u_tmo (
      .clk   (clk),
      .rst_n (rst_i),
      .deny  (rd_en[a] && !win[a]),
      .grant (win[a]),
      .flag  (timeout[a])
    );
  end

  assign release_lock = |rel;

  always_comb begin
    own_v_d  = own_v_q;
    own_id_d = own_id_q;
    ptr_d    = ptr_q;
    if (any_win) begin
      own_v_d  = 1'b1;
      own_id_d = win_id;
      ptr_d    = AW'(wrap_next(int'(win_id), N_AGENTS));
    end else if (release_lock) begin
      own_v_d  = 1'b0;
    end
  end

  assign state_en = any_win | release_lock;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      own_v_q  <= 1'b0;
      own_id_q <= '0;
      ptr_q    <= '0;
    end else if (state_en) begin
      own_v_q  <= own_v_d;
      own_id_q <= own_id_d;
      ptr_q    <= ptr_d;
    end
  end

  assign owned = own_v_q;
  assign owner = own_id_q;

endmodule

// File: rtl/hsem_chk.sv
module hsem_chk
  import hsem_pkg::*;
#(
  parameter int N  = 2,
  parameter int DW = 32,
  localparam int AW = agent_w(N)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    rd_en,
  input logic [N-1:0]    wr_en,
  input logic [N*DW-1:0] wr_data,
  input logic [N*DW-1:0] rd_data,
  input logic [N-1:0]    timeout,
  input logic            owned,
  input logic [AW-1:0]   owner
);

  logic [N-1:0] hit;
  logic         owner_rel;

  always_comb begin
    owner_rel = 1'b0;
    for (int a = 0; a < N; a++) begin
      hit[a] = rd_data[a*DW];
      if (wr_en[a] && owned && owner == AW'(a) &&
          wr_data[a*DW +: DW] == DW'(RELEASE_WORD))
        owner_rel = 1'b1;
    end
  end

  // R4
  one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  // R5
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owner_rel |=> !owned);

  // R6
  owner_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && !owner_rel) |=> (owned && $stable(owner)));

  for (genvar a = 0; a < N; a++) begin : g_a
    // R2
    grant_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[a] |-> (owned && owner == AW'(a)));

    // R3
    held_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owned && rd_en[a]) |=> (rd_data[a*DW +: DW] == '0));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[a] |=> (rd_data[a*DW +: DW] == '0));

    // R8
    sticky_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout[a] |=> timeout[a]);
  end

endmodule

bind hsem_top hsem_chk #(.N(N_AGENTS), .DW(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .timeout (timeout),
  .owned   (owned),
  .owner   (owner)
);

// File: tb/tb_hsem_top.sv
`timescale 1ns/1ps
module tb_hsem_top;

  localparam int N   = 2;
  localparam int DW  = 32;
  localparam int TMO = 20;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  rd_en;
  logic [N-1:0]  wr_en;
  logic [N*DW-1:0] wr_data;
  logic [N*DW-1:0] rd_data;
  logic [N-1:0]  timeout;
  logic          owned;
  logic          owner;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Bench model of the lock, built from the requirements.
  bit m_own;
  int m_id;
  int m_ptr;
  bit m_arm [N];
  int m_cnt [N];
  bit m_flag[N];

  hsem_top #(.N_AGENTS(N), .DATA_W(DW), .TMO_CYCLES(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .timeout(timeout),
    .owned(owned), .owner(owner)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int other(input int a);
    return (a + 1 >= N) ? 0 : a + 1;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; rd_en = '0; wr_en = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_own = 0; m_id = 0; m_ptr = 0;
    for (int a = 0; a < N; a++) begin m_arm[a] = 0; m_cnt[a] = 0; m_flag[a] = 0; end
    chk(owned == 1'b0, "R1 owned", owned, 0);
    chk(timeout == '0, "R1 timeout", timeout, 0);
    chk(rd_data == '0, "R1 rd_data", rd_data, 0);
  endtask

  // One cycle: drive at a falling edge, check after the next falling edge.
  task automatic step(input logic [N-1:0] r, input logic [N-1:0] w,
                      input logic [DW-1:0] d0, input logic [DW-1:0] d1);
    int  win;
    bit  rel;
    bit  held;
    logic [DW-1:0] dd[N];
    string rtag[N];
    string otag;
    dd[0] = d0; dd[1] = d1;
    held = m_own;
    win  = -1;
    if (!m_own) begin
      if (r[m_ptr]) win = m_ptr;
      else if (r[other(m_ptr)]) win = other(m_ptr);
    end
    rel = m_own && w[m_id] && dd[m_id] == DW'(1);
    for (int a = 0; a < N; a++) begin
      if (!r[a])                 rtag[a] = "R9 read idle";
      else if (rel && a != m_id) rtag[a] = "R7 read at release";
      else if (held)             rtag[a] = "R3 read held";
      else if (r == '1)          rtag[a] = "R4 contested read";
      else                       rtag[a] = "R2 read free";
    end
    if (rel)          otag = "R5 release";
    else if (w != '0) otag = "R6 ignored write";
    else              otag = "R2 owner";
    // model update
    for (int a = 0; a < N; a++) begin
      if (win == a) begin
        m_arm[a] = 0; m_cnt[a] = 0;
      end else if (m_arm[a]) begin
        if (!m_flag[a]) begin
          m_cnt[a]++;
          if (m_cnt[a] == TMO) m_flag[a] = 1;
        end
      end else if (r[a]) begin
        m_arm[a] = 1; m_cnt[a] = 0;
      end
    end
    if (win >= 0) begin m_own = 1; m_id = win; m_ptr = other(win); end
    else if (rel) m_own = 0;
    rd_en = r; wr_en = w; wr_data = {d1, d0};
    @(negedge clk);
    rd_en = '0; wr_en = '0;
    for (int a = 0; a < N; a++) begin
      chk(rd_data[a*DW +: DW] == DW'(win == a), rtag[a], rd_data[a*DW +: DW], (win == a));
      chk(timeout[a] == m_flag[a], "R8 timeout", timeout[a], m_flag[a]);
    end
    chk(owned == m_own, otag, owned, m_own);
    if (m_own) chk(owner == 1'(m_id), otag, owner, m_id);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(2'b00, 2'b00, '0, '0);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] rdat;
    void'($urandom(32'h5EA1));
    do_reset();

    // R2, R3: single reader, repeated read by owner, read by other
    step(2'b01, 2'b00, '0, '0);
    chk(owner == 1'b0, "R2 owner id", owner, 0);
    step(2'b01, 2'b00, '0, '0);
    step(2'b10, 2'b00, '0, '0);
    // R6: non-owner writes 1, owner writes 2 and 3
    step(2'b00, 2'b10, '0, 32'd1);
    step(2'b00, 2'b01, 32'd2, '0);
    step(2'b00, 2'b01, 32'd3, '0);
    chk(owned == 1'b1, "R6 still owned", owned, 1);
    // R5: owner releases
    step(2'b00, 2'b01, 32'd1, '0);
    chk(owned == 1'b0, "R5 freed", owned, 0);
    // R4: priority now with agent 1, then back to agent 0
    step(2'b11, 2'b00, '0, '0);
    chk(owner == 1'b1, "R4 agent1 wins", owner, 1);
    step(2'b00, 2'b10, '0, 32'd1);
    step(2'b11, 2'b00, '0, '0);
    chk(owner == 1'b0, "R4 agent0 wins", owner, 0);
    // R7: release with concurrent read by the other agent
    step(2'b10, 2'b01, 32'd1, '0);
    chk(owned == 1'b0, "R7 free after", owned, 0);

    // R8: exact timeout edge
    do_reset();
    step(2'b01, 2'b00, '0, '0);
    step(2'b10, 2'b00, '0, '0);
    idle(TMO - 1);
    chk(timeout[1] == 1'b0, "R8 not yet", timeout[1], 0);
    idle(1);
    chk(timeout[1] == 1'b1, "R8 raised", timeout[1], 1);
    step(2'b00, 2'b01, 32'd1, '0);
    step(2'b10, 2'b00, '0, '0);
    idle(5);
    chk(timeout[1] == 1'b1, "R8 sticky", timeout[1], 1);

    // R8: grant in time disarms
    do_reset();
    step(2'b01, 2'b00, '0, '0);
    step(2'b10, 2'b00, '0, '0);
    idle(TMO / 2);
    step(2'b00, 2'b01, 32'd1, '0);
    step(2'b10, 2'b00, '0, '0);
    idle(TMO * 2);
    chk(timeout[1] == 1'b0, "R8 disarmed", timeout[1], 0);

    // Random mix
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] r, w;
      logic [DW-1:0] d[N];
      r = 2'($urandom_range(0, 3));
      w = 2'($urandom_range(0, 3));
      for (int a = 0; a < N; a++) begin
        case ($urandom_range(0, 3))
          0: d[a] = 32'd1;
          1: d[a] = 32'd0;
          2: d[a] = 32'd3;
          default: d[a] = $urandom();
        endcase
      end
      if ($urandom_range(0, 1) == 0) r = '0;
      step(r, w, d[0], d[1]);
      if (i % 1000 == 999) do_reset();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule